// File: doc/BRIEF.md
# Programmable I2C Clock Phase and Condition Generator

This block produces the serial clock of an I2C master from a fast reference clock, using separate programmable lengths for the clock-low and clock-high phases instead of a plain divider. Inside each phase an offset count places a one-cycle strobe: inside the low phase it tells the transfer engine when to change SDA, and inside the high phase it tells the engine when to sample SDA. At the end of every high phase a slot pulse marks a finished bit. The block also forms the start and stop conditions around the bit slots, with setup and hold counts taken from a third timing word.

The clock is open-drain: the block only pulls SCL low or releases it, and the high phase does not start counting until the line reads back high. A slave that holds SCL low therefore stretches the slot. A package function gives the default timing words for a requested bus rate from a 24 MHz reference. The usual setup word holds 0x30 in both fields.

The controller has ten states. S_IDLE goes to S_START_SU on a start request ("accept"). S_START_SU goes to S_START_HD when the setup count ends ("start_setup_done"). S_START_HD goes to S_LOW when the hold count ends ("start_hold_done"). S_LOW goes to S_WAIT_HI when the low count ends ("release"). S_WAIT_HI goes to S_HIGH once SCL reads high ("seen_high"). S_HIGH returns to S_LOW when the high count ends ("next_slot"), or goes to S_STOP_LO if a stop is pending ("stop_begin"). S_STOP_LO goes to S_STOP_WAIT when the low count ends ("stop_release"). S_STOP_WAIT goes to S_STOP_SU once SCL reads high ("stop_seen_high"). S_STOP_SU goes to S_STOP_HD when the setup count ends ("stop_setup_done"). S_STOP_HD goes to S_IDLE when the hold count ends ("stop_hold_done").

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset the block is idle: busy=0, SCL and SDA are released (scl_low=0, sda_low=0), and no strobe is active.
- R2: Timing field positions: tim_a[31:16] is the high-phase length and tim_a[15:0] the sample offset; tim_b[31:16] is the low-phase length and tim_b[15:0] the change offset; tim_c[31:16] is the condition setup length and tim_c[15:0] the condition hold length. All are counts of reference cycles, and a length of 0 acts as 1.
- R3: A start request taken while idle first keeps both lines released for the setup length. It then forces SDA low with SCL still released for the hold length, and then begins the first low phase.
- R4: Each low phase pulls SCL low for the low length. tx_stb pulses once, at offset tx within the phase, only when that offset is below the phase length.
- R5: After a low phase SCL is released, and the high phase begins on the cycle after scl_in is seen high, so a stretching slave adds one cycle per held cycle.
- R6: Each high phase lasts the high length. rx_stb pulses once, at offset rx, only when that offset is below the phase length. slot_end pulses on the last cycle of the phase.
- R7: A stop request made while busy is remembered. After the current high phase, SCL is held low for one low length with SDA forced low, then released, and the block waits for SCL high. SDA stays low for the setup length, is then released, and the block waits out the hold length before going idle.
- R8: busy rises in the first cycle after the start is accepted and falls in the first cycle after the stop hold ends.
- R9: A start request made while busy has no effect on any output.
- R10: The default timing function clamps the rate to 12 kHz..540 kHz and sets base=(24e6/rate-38)/2, high=base+3, low=base-3, sample=3*high/4 and change=low/4, with integer division throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_a | input | 32 | High length and sample offset |
| tim_b | input | 32 | Low length and change offset |
| tim_c | input | 32 | Condition setup and hold lengths |
| start_req | input | 1 | Request a start condition and bit slots |
| stop_req | input | 1 | Request a stop after the current slot |
| scl_in | input | 1 | SCL line read back |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Force SDA low for start/stop |
| tx_stb | output | 1 | SDA change point |
| rx_stb | output | 1 | SDA sample point |
| slot_end | output | 1 | Last cycle of a bit slot |
| busy | output | 1 | Transfer in progress |

## Verification
Each output is decoded from the registered state, so a request taken at a clock edge first shows in the cycle after that edge, and every later event lands at a fixed offset from that cycle. Define s as the first cycle of setup. SDA falls at s+SU. The first low phase starts at L0=s+SU+HD, with the change strobe at L0+tx. The high phase starts at H0=L0+LO+1+k, where k is the number of stretch cycles; the sample strobe is at H0+rx and slot_end is at H0+HI-1. The stop SDA release and the busy drop follow the same way. The bench computes these cycle numbers from the timing words into a queue and compares each observed edge or strobe, together with its cycle number, at the falling clock edge.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_START_SU, S_START_HD, S_LOW, S_WAIT_HI,
        S_HIGH, S_STOP_LO, S_STOP_WAIT, S_STOP_SU, S_STOP_HD
    } tgen_state_e;

    localparam int unsigned REF_HZ   = 24000000;
    localparam int unsigned RATE_MIN = 12000;
    localparam int unsigned RATE_MAX = 540000;
    localparam logic [31:0] COND_DEFAULT = 32'h0030_0030;

    // returns {tim_a, tim_b} for a requested bus rate
    function automatic logic [63:0] default_timing(input int unsigned rate);
        int unsigned r, base, hi, lo, rx, tx;
        r    = (rate > RATE_MAX) ? RATE_MAX : ((rate < RATE_MIN) ? RATE_MIN : rate);
        base = (REF_HZ / r - 38) / 2;
        hi   = base + 3;
        lo   = base - 3;
        rx   = (hi * 3) / 4;
        tx   = lo / 4;
        return {hi[15:0], rx[15:0], lo[15:0], tx[15:0]};
    endfunction

endpackage

// File: rtl/scl_tgen_cnt.sv
module scl_tgen_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clr)            cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/scl_tgen_fsm.sv
module scl_tgen_fsm
    import scl_tgen_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          scl_in,
    input  logic [FW-1:0] hi_len,
    input  logic [FW-1:0] rx_pt,
    input  logic [FW-1:0] lo_len,
    input  logic [FW-1:0] tx_pt,
    input  logic [FW-1:0] su_len,
    input  logic [FW-1:0] hd_len,
    input  logic [FW-1:0] cnt,
    output logic          cnt_clr,
    output logic          scl_low,
    output logic          sda_low,
    output logic          tx_stb,
    output logic          rx_stb,
    output logic          slot_end,
    output logic          busy
);
    tgen_state_e state, state_nxt;
    logic          stop_pend;
    logic [FW-1:0] ph_len;
    logic [FW:0]   cnt_p1;
    logic          ph_last;

    // length of the phase the current state counts
    always_comb begin
        unique case (state)
            S_START_SU, S_STOP_SU: ph_len = su_len;
            S_START_HD, S_STOP_HD: ph_len = hd_len;
            S_LOW, S_STOP_LO:      ph_len = lo_len;
            S_HIGH:                ph_len = hi_len;
            default:               ph_len = '0;
        endcase
    end

    assign cnt_p1  = {1'b0, cnt} + {{FW{1'b0}}, 1'b1};
    assign ph_last = (cnt_p1 >= {1'b0, ph_len});

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:      if (start_req) state_nxt = S_START_SU;
            S_START_SU:  if (ph_last)   state_nxt = S_START_HD;
            S_START_HD:  if (ph_last)   state_nxt = S_LOW;
            S_LOW:       if (ph_last)   state_nxt = S_WAIT_HI;
            S_WAIT_HI:   if (scl_in)    state_nxt = S_HIGH;
            S_HIGH:      if (ph_last)   state_nxt = (stop_pend || stop_req) ? S_STOP_LO : S_LOW;
            S_STOP_LO:   if (ph_last)   state_nxt = S_STOP_WAIT;
            S_STOP_WAIT: if (scl_in)    state_nxt = S_STOP_SU;
            S_STOP_SU:   if (ph_last)   state_nxt = S_STOP_HD;
            S_STOP_HD:   if (ph_last)   state_nxt = S_IDLE;
            default:                    state_nxt = S_IDLE;
        endcase
    end

    assign cnt_clr = (state_nxt != state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            stop_pend <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == S_IDLE || state_nxt == S_STOP_LO) stop_pend <= 1'b0;
            else if (stop_req)                             stop_pend <= 1'b1;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        scl_low  = 1'b0;
        sda_low  = 1'b0;
        tx_stb   = 1'b0;
        rx_stb   = 1'b0;
        slot_end = 1'b0;
        busy     = 1'b1;
        unique case (state)
            S_IDLE:      busy = 1'b0;
            S_START_SU:  ;
            S_START_HD:  sda_low = 1'b1;
            S_LOW: begin
                scl_low = 1'b1;
                tx_stb  = (cnt == tx_pt);
            end
            S_WAIT_HI:   ;
            S_HIGH: begin
                rx_stb   = (cnt == rx_pt);
                slot_end = ph_last;
            end
            S_STOP_LO: begin
                scl_low = 1'b1;
                sda_low = 1'b1;
            end
            S_STOP_WAIT: sda_low = 1'b1;
            S_STOP_SU:   sda_low = 1'b1;
            S_STOP_HD:   ;
            default:     busy = 1'b0;
        endcase
    end

    a_r4_tx_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> scl_low);
    a_r6_rx_while_released: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> (!scl_low && !tx_stb));
    a_r5_high_after_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH && $past(state) == S_WAIT_HI) |-> $past(scl_in));
    a_r3_accept_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_req) |=> (busy && !scl_low && !sda_low));
    a_r7_stop_sda_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_low) && !scl_low) |-> !$past(scl_low));
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_low && !sda_low && !slot_end));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tgen_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*FW-1:0] tim_a,
    input  logic [2*FW-1:0] tim_b,
    input  logic [2*FW-1:0] tim_c,
    input  logic            start_req,
    input  logic            stop_req,
    input  logic            scl_in,
    output logic            scl_low,
    output logic            sda_low,
    output logic            tx_stb,
    output logic            rx_stb,
    output logic            slot_end,
    output logic            busy
);
    localparam int HI_LSB = FW;

    logic [FW-1:0] cnt;
    logic          cnt_clr;

    scl_tgen_cnt #(.W(FW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    scl_tgen_fsm #(.FW(FW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .scl_in    (scl_in),
        .hi_len    (tim_a[HI_LSB +: FW]),
        .rx_pt     (tim_a[0 +: FW]),
        .lo_len    (tim_b[HI_LSB +: FW]),
        .tx_pt     (tim_b[0 +: FW]),
        .su_len    (tim_c[HI_LSB +: FW]),
        .hd_len    (tim_c[0 +: FW]),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .scl_low   (scl_low),
        .sda_low   (sda_low),
        .tx_stb    (tx_stb),
        .rx_stb    (rx_stb),
        .slot_end  (slot_end),
        .busy      (busy)
    );
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
    import scl_tgen_pkg::*;

    localparam int EV_TX = 0, EV_RX = 1, EV_SLOT = 2, EV_SDA_DN = 3, EV_SDA_UP = 4, EV_IDLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] tim_a = '0, tim_b = '0, tim_c = '0;
    logic start_req = 1'b0, stop_req = 1'b0, scl_in = 1'b1;
    logic scl_low, sda_low, tx_stb, rx_stb, slot_end, busy;

    int cyc = 0, n_chk = 0, n_bad = 0, hold_n = 0, sc = 0;
    int exp_kind[$], exp_cyc[$];
    logic sda_q = 1'b0, busy_q = 1'b0, scl_q = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .tim_a(tim_a), .tim_b(tim_b), .tim_c(tim_c),
        .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
        .scl_low(scl_low), .sda_low(sda_low), .tx_stb(tx_stb), .rx_stb(rx_stb),
        .slot_end(slot_end), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // monitor: pop and compare each observed event
    task automatic got(input int kind);
        n_chk++;
        if (exp_kind.size() == 0) begin
            n_bad++;
            $display("FAIL R3-R7 event: actual kind %0d at %0d expected none", kind, cyc);
        end else begin
            int k = exp_kind.pop_front();
            int c = exp_cyc.pop_front();
            if (k != kind || c != cyc) begin
                n_bad++;
                $display("FAIL R3-R7 event: actual kind %0d at %0d expected kind %0d at %0d",
                         kind, cyc, k, c);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_low && !sda_q)  got(EV_SDA_DN);
            if (!sda_low && sda_q)  got(EV_SDA_UP);
            if (tx_stb)             got(EV_TX);
            if (rx_stb)             got(EV_RX);
            if (slot_end)           got(EV_SLOT);
            if (!busy && busy_q)    got(EV_IDLE);
            // slave model: hold SCL low for hold_n cycles after release
            if (scl_q && !scl_low) sc = hold_n;
            scl_in = !scl_low && (sc == 0);
            if (sc > 0 && !scl_low) sc--;
        end
        sda_q  = sda_low;
        busy_q = busy;
        scl_q  = scl_low;
    end

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic push(input int kind, input int c);
        exp_kind.push_back(kind);
        exp_cyc.push_back(c);
    endtask

    // driver: one transfer of n slots, optional start pulse at s+inj while busy
    task automatic run_xfer(input int n, input int k, input int hi, input int rx,
                            input int lo, input int tx, input int su, input int hd,
                            input int inj);
        int s, l0, h0, stop_at, idle_at, ssu, shd, slo, shi;
        tim_a = {hi[15:0], rx[15:0]};
        tim_b = {lo[15:0], tx[15:0]};
        tim_c = {su[15:0], hd[15:0]};
        hold_n = k;
        ssu = eff(su); shd = eff(hd); slo = eff(lo); shi = eff(hi);
        start_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_req = 1'b0;
        s = cyc;
        check("R8 busy rise", int'(busy), 1);
        push(EV_SDA_DN, s + ssu);               // R3 start: SDA low, SCL high
        l0 = s + ssu + shd;
        push(EV_SDA_UP, l0);                    // engine takes SDA in low phase
        stop_at = l0;
        for (int i = 0; i < n; i++) begin
            stop_at = l0;
            if (tx < slo) push(EV_TX, l0 + tx); // R4
            h0 = l0 + slo + 1 + k;              // R5
            if (rx < shi) push(EV_RX, h0 + rx); // R6
            push(EV_SLOT, h0 + shi - 1);        // R6
            l0 = h0 + shi;
        end
        push(EV_SDA_DN, l0);                    // R7 stop low phase
        idle_at = l0 + slo + 1 + k + ssu;
        push(EV_SDA_UP, idle_at);               // R7 release with SCL high
        idle_at = idle_at + shd;
        push(EV_IDLE, idle_at);                 // R8
        while (cyc < idle_at + 3) begin
            stop_req  = (cyc == stop_at);
            start_req = (inj >= 0 && cyc == s + inj); // R9
            @(negedge clk);
        end
        stop_req = 1'b0;
        start_req = 1'b0;
        check("R7 events left", exp_kind.size(), 0);
        check("R8 busy low", int'(busy), 0);
        check("R1 lines released", int'(scl_low) + int'(sda_low), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin : main
        logic [63:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 scl", int'(scl_low), 0);
        check("R1 sda", int'(sda_low), 0);
        check("R1 strobes", int'(tx_stb) + int'(rx_stb) + int'(slot_end), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'(busy), 0);

        // R10 default timing function
        d = default_timing(100000);
        check("R10 100k hi", int'(d[63:48]), 104); check("R10 100k rx", int'(d[47:32]), 78);
        check("R10 100k lo", int'(d[31:16]), 98);  check("R10 100k tx", int'(d[15:0]), 24);
        d = default_timing(400000);
        check("R10 400k hi", int'(d[63:48]), 14);  check("R10 400k rx", int'(d[47:32]), 10);
        check("R10 400k lo", int'(d[31:16]), 8);   check("R10 400k tx", int'(d[15:0]), 2);
        d = default_timing(1000000);
        check("R10 clamp hi", int'(d[63:48]), 6);  check("R10 clamp lo", int'(d[31:16]), 0);
        d = default_timing(5000);
        check("R10 clamp low rate hi", int'(d[63:48]), 984);
        check("R10 clamp low rate tx", int'(d[15:0]), 244);

        // R2 R3 R4 R6 R7 R8 default 100 kHz setting, one slot
        run_xfer(1, 0, 104, 78, 98, 24, 48, 48, -1);
        // R2 R4 R6 short custom phases, three slots
        run_xfer(3, 0, 6, 2, 5, 1, 3, 2, -1);
        // R5 clock stretching, two slots
        run_xfer(2, 4, 6, 2, 5, 1, 3, 2, -1);
        // R2 zero lengths act as one cycle
        run_xfer(2, 0, 0, 0, 0, 0, 0, 0, -1);
        // R4 R6 offsets beyond phase give no strobe
        run_xfer(2, 1, 4, 7, 3, 3, 2, 2, -1);
        // R9 start request while busy is ignored
        run_xfer(2, 0, 6, 2, 5, 1, 3, 2, 9);
        summary();
    end
endmodule